// File: doc/BRIEF.md
# I2C Register Read Master

This block is a single-controller I2C engine. It performs one fixed register read over two open-drain lines. A one-cycle start request latches a 7-bit target address and an 8-bit register index, then the engine runs the whole transfer in order:

1. It generates a START condition.
2. It sends the address byte with the direction bit set to read, then checks the target's acknowledge.
3. It sends the register index, then checks that acknowledge too.
4. It clocks in one data byte and acknowledges it.
5. It holds the bus for one extra bit period, then generates a STOP condition.

If either acknowledge is missing, the engine does not send that byte again. It goes straight to STOP and reports an error.

Both bus lines are represented as pull-low enables. When an enable is low the pad is released, and the external pull-up takes the line high. The incoming SDA level passes through a two-flop synchroniser. Bus timing comes from a divider on the system clock. Each bit period has four equal quarters:
- SDA is changed at the start of the first quarter.
- SCL is high during the second and third quarters.
- SDA is sampled at the end of the third quarter.

Top module: `i2c_reg_read_master`

## Requirements
- R1: While reset is asserted, and whenever no transfer is in progress, both pull-low enables are 0 and `busy_o`, `done_o` and `ack_err_o` are 0. After reset, `rd_data_o` is 0x00.
- R2: START is SDA pulled low at the start of the third quarter of the first slot, while SCL is released. STOP is a slot in which SCL is low in the first quarter, SDA is low in the first two quarters, and SDA is released from the third quarter on, while SCL is high.
- R3: Apart from START and STOP, SDA changes only while SCL was low in the cycle before and is still low in the current cycle.
- R4: The first byte after START is {address[6:0], 1'b1}. The second byte is the register index. Both are sent most significant bit first, with SDA pulled low for a 0 bit. In each byte's ninth slot the master releases SDA.
- R5: If SDA is high when sampled in the address acknowledge slot, no register index is sent. The next slot is STOP. The transfer ends with `done_o` and `ack_err_o` high, and `rd_data_o` unchanged.
- R6: If the register index is not acknowledged (SDA high when sampled), the transfer goes straight to STOP. It ends with `done_o` and `ack_err_o` high, and `rd_data_o` unchanged.
- R7: After an acknowledged register index, the master releases SDA for eight slots and assembles the sampled bits most significant first. It pulls SDA low in the ninth slot. It then holds SCL and SDA low for one full slot before STOP. The byte appears on `rd_data_o` in the `done_o` cycle.
- R8: `busy_o` is 1 from the cycle after the accepting edge through the last STOP cycle, and falls in the `done_o` cycle. A start request while `busy_o` is 1 changes neither the lines nor the latched operands.
- R9: Every quarter lasts exactly QDIV clock cycles. In each byte slot, SCL is pulled low in the first and fourth quarters and released in the second and third.
- R10: `done_o` is a single-cycle pulse at the end of each transfer. `ack_err_o` is high only in a `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a read transfer; honoured only while idle |
| dev_addr_i | input | 7 | Target address, latched on the accepting edge |
| reg_idx_i | input | 8 | Register index, latched on the accepting edge |
| sda_in_i | input | 1 | Level seen on the SDA pad |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data_o | output | 8 | Last byte read successfully |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ack_err_o | output | 1 | Acknowledge missing; valid with `done_o` |

## Verification
Two events can fall in the same cycle: a start request and the edge that retires the STOP slot. The bench holds `start_i` high through the final cycles of STOP, including that very edge, and also during a window in mid-transfer. A reference model built from the requirements predicts the expected line pattern for every cycle. That pattern must not change, and `busy_o` must then stay low after `done_o`. The bench also samples the target's bit in the same cycle that the master moves into the next quarter. The model's target drives the line for the whole slot, so any sampling in the wrong quarter shows up as a wrong byte or a wrong abort.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [2:0] {
    K_IDLE,
    K_START,
    K_ADDR,
    K_REG,
    K_DATA,
    K_GAP,
    K_STOP
  } slot_e;
endpackage

// File: rtl/rdm_qtick.sv
module rdm_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!run || cnt_q == LAST) cnt_n = '0;
    else                       cnt_n = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  generate
    if (QDIV > 1) begin : g_chk
      assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rdm_rx.sv
module rdm_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sda_in,
  input  logic         sample,
  input  logic         shift,
  output logic         bit_o,
  output logic [W-1:0] byte_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      bit_o  <= 1'b1;
      byte_o <= '0;
    end else begin
      meta_q <= sda_in;
      sync_q <= meta_q;
      if (sample) bit_o  <= sync_q;
      if (shift)  byte_o <= {byte_o[W-2:0], sync_q};
    end
  end

  assert_shift_on_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> sample);
endmodule

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] reg_idx_i,
  input  logic              rx_bit,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              run,
  output logic              sample,
  output logic              shift,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              done_o,
  output logic              ack_err_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ACK = CW'(BYTE_W);

  slot_e             kind_q, kind_n;
  logic [1:0]        q_q, q_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] tx_q, tx_n, reg_q, reg_n;
  logic              pend_q, pend_n, fin;
  logic              scl_n, sda_n;

  assign run    = (kind_q != K_IDLE);
  assign sample = tick && (q_q == 2'd2) &&
                  (kind_q == K_ADDR || kind_q == K_REG || kind_q == K_DATA);
  assign shift  = sample && (kind_q == K_DATA) && (cnt_q != ACK);

  // next-state: slot sequencing
  always_comb begin
    kind_n = kind_q;
    q_n    = q_q;
    cnt_n  = cnt_q;
    tx_n   = tx_q;
    reg_n  = reg_q;
    pend_n = pend_q;
    fin    = 1'b0;
    if (kind_q == K_IDLE) begin
      if (start_i) begin
        kind_n = K_START;
        q_n    = 2'd0;
        cnt_n  = '0;
        tx_n   = {dev_addr_i, 1'b1};
        reg_n  = reg_idx_i;
        pend_n = 1'b0;
      end
    end else if (tick) begin
      q_n = q_q + 2'd1;
      if (q_q == 2'd3) begin
        unique case (kind_q)
          K_START: begin
            kind_n = K_ADDR;
            cnt_n  = '0;
          end
          K_ADDR, K_REG: begin
            if (cnt_q != ACK) begin
              cnt_n = cnt_q + 1'b1;
              tx_n  = {tx_q[BYTE_W-2:0], 1'b0};
            end else if (rx_bit) begin
              kind_n = K_STOP;
              pend_n = 1'b1;
            end else if (kind_q == K_ADDR) begin
              kind_n = K_REG;
              cnt_n  = '0;
              tx_n   = reg_q;
            end else begin
              kind_n = K_DATA;
              cnt_n  = '0;
            end
          end
          K_DATA: begin
            if (cnt_q != ACK) cnt_n = cnt_q + 1'b1;
            else              kind_n = K_GAP;
          end
          K_GAP:  kind_n = K_STOP;
          K_STOP: begin
            kind_n = K_IDLE;
            fin    = 1'b1;
          end
          default: kind_n = K_IDLE;
        endcase
      end
    end
  end

  // next-state: line drive derived from the upcoming slot and quarter
  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    unique case (kind_n)
      K_START: begin
        scl_n = (q_n == 2'd3);
        sda_n = q_n[1];
      end
      K_ADDR, K_REG: begin
        scl_n = (q_n == 2'd0) || (q_n == 2'd3);
        sda_n = (cnt_n != ACK) && !tx_n[BYTE_W-1];
      end
      K_DATA: begin
        scl_n = (q_n == 2'd0) || (q_n == 2'd3);
        sda_n = (cnt_n == ACK);
      end
      K_GAP: begin
        scl_n = 1'b1;
        sda_n = 1'b1;
      end
      K_STOP: begin
        scl_n = (q_n == 2'd0);
        sda_n = !q_n[1];
      end
      default: begin
        scl_n = 1'b0;
        sda_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= K_IDLE;
      q_q       <= 2'd0;
      cnt_q     <= '0;
      tx_q      <= '0;
      reg_q     <= '0;
      pend_q    <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
      ack_err_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      kind_q    <= kind_n;
      q_q       <= q_n;
      cnt_q     <= cnt_n;
      tx_q      <= tx_n;
      reg_q     <= reg_n;
      pend_q    <= pend_n;
      scl_low_o <= scl_n;
      sda_low_o <= sda_n;
      done_o    <= fin;
      ack_err_o <= fin && pend_q;
      if (fin && !pend_q) rd_data_o <= rx_byte;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_IDLE) |-> (!scl_low_o && !sda_low_o));
  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_low_o) && !scl_low_o && !$past(scl_low_o)) |->
      (kind_q == K_START || kind_q == K_STOP));
  assert_scl_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_low_o) |-> $past(tick));
  assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> done_o);
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start_i) |=> $stable(reg_q));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err_o |-> done_o);
endmodule

// File: rtl/i2c_reg_read_master.sv
module i2c_reg_read_master
  import rdm_pkg::*;
#(
  parameter int QDIV = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] reg_idx_i,
  input  logic              sda_in_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_err_o
);
  logic rst_meta_q, rst_sync_q;
  logic tick, run, sample, shift, rx_bit;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rdm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .run   (run),
    .tick  (tick)
  );

  rdm_rx #(.W(BYTE_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .sda_in (sda_in_i),
    .sample (sample),
    .shift  (shift),
    .bit_o  (rx_bit),
    .byte_o (rx_byte)
  );

  rdm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .tick       (tick),
    .start_i    (start_i),
    .dev_addr_i (dev_addr_i),
    .reg_idx_i  (reg_idx_i),
    .rx_bit     (rx_bit),
    .rx_byte    (rx_byte),
    .run        (run),
    .sample     (sample),
    .shift      (shift),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .done_o     (done_o),
    .ack_err_o  (ack_err_o),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = run;
endmodule

// File: tb/test_i2c_reg_read_master.sv
module test_i2c_reg_read_master;
  localparam int QD    = 4;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [6:0] dev_addr;
  logic [7:0] reg_idx;
  logic       tgt_low;
  logic       scl_low, sda_low, busy, done, ack_err;
  logic [7:0] rd_data;
  wire        sda_in = ~(sda_low | tgt_low);

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0] exp_rd;

  logic  eq_scl[$];
  logic  eq_sda[$];
  logic  eq_tgt[$];
  string eq_tag[$];

  always #2 clk = ~clk;

  i2c_reg_read_master #(.QDIV(QD)) i_i2c_reg_read_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dev_addr_i (dev_addr),
    .reg_idx_i  (reg_idx),
    .sda_in_i   (sda_in),
    .scl_low_o  (scl_low),
    .sda_low_o  (sda_low),
    .rd_data_o  (rd_data),
    .busy_o     (busy),
    .done_o     (done),
    .ack_err_o  (ack_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic pq(input logic s, input logic d, input logic t, input string tag);
    eq_scl.push_back(s);
    eq_sda.push_back(d);
    eq_tgt.push_back(t);
    eq_tag.push_back(tag);
  endtask

  // byte slot: SCL low in quarters 0 and 3 (R9)
  task automatic put_slot(input logic m, input logic t, input string tag);
    pq(1'b1, m, t, tag);
    pq(1'b0, m, t, tag);
    pq(1'b0, m, t, tag);
    pq(1'b1, m, t, tag);
  endtask

  task automatic put_stop();
    pq(1'b1, 1'b1, 1'b0, "R2");
    pq(1'b0, 1'b1, 1'b0, "R2");
    pq(1'b0, 1'b0, 1'b0, "R2");
    pq(1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic build(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                       input bit ack_a, input bit ack_r);
    logic [7:0] ab;
    ab = {a, 1'b1};
    eq_scl.delete(); eq_sda.delete(); eq_tgt.delete(); eq_tag.delete();
    pq(1'b0, 1'b0, 1'b0, "R2");
    pq(1'b0, 1'b0, 1'b0, "R2");
    pq(1'b0, 1'b1, 1'b0, "R2");
    pq(1'b1, 1'b1, 1'b0, "R2");
    for (int i = 7; i >= 0; i--) put_slot(~ab[i], 1'b0, "R4");
    put_slot(1'b0, ack_a, "R5");
    if (!ack_a) begin put_stop(); return; end
    for (int i = 7; i >= 0; i--) put_slot(~r[i], 1'b0, "R4");
    put_slot(1'b0, ack_r, "R6");
    if (!ack_r) begin put_stop(); return; end
    for (int i = 7; i >= 0; i--) put_slot(1'b0, ~d[i], "R7");
    put_slot(1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) pq(1'b1, 1'b1, 1'b0, "R7");
    put_stop();
  endtask

  task automatic run_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                         input bit ack_a, input bit ack_r, input bit poke);
    int  total;
    int  k;
    bit  err_exp;
    string etag;
    build(a, r, d, ack_a, ack_r);
    total   = eq_scl.size() * QD;
    err_exp = !(ack_a && ack_r);
    etag    = !ack_a ? "R5" : (!ack_r ? "R6" : "R7");
    @(negedge clk);
    dev_addr = a;
    reg_idx  = r;
    start_i  = 1'b1;
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      k = j / QD;
      if (poke && ((j >= 40 && j < 80) || j >= total - 8)) begin
        start_i  = 1'b1;
        dev_addr = ~a;
        reg_idx  = ~r;
      end else begin
        start_i = 1'b0;
      end
      tgt_low = eq_tgt[k];
      chk(scl_low === eq_scl[k], {eq_tag[k], " R9 scl"}, int'(scl_low), int'(eq_scl[k]));
      chk(sda_low === eq_sda[k], {eq_tag[k], " R3 sda"}, int'(sda_low), int'(eq_sda[k]));
      chk(busy === 1'b1, "R8 busy during transfer", int'(busy), 1);
      chk(done === 1'b0, "R10 done early", int'(done), 0);
    end
    @(negedge clk);
    start_i = 1'b0;
    tgt_low = 1'b0;
    if (!err_exp) exp_rd = d;
    chk(done === 1'b1, "R10 done pulse", int'(done), 1);
    chk(ack_err === err_exp, {etag, " ack_err"}, int'(ack_err), int'(err_exp));
    chk(rd_data === exp_rd, {etag, " rd_data"}, int'(rd_data), int'(exp_rd));
    chk(busy === 1'b0, "R8 busy falls with done", int'(busy), 0);
    chk(!scl_low && !sda_low, "R1 lines released at end", int'({scl_low, sda_low}), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done single cycle", int'(done), 0);
    chk(ack_err === 1'b0, "R10 err only with done", int'(ack_err), 0);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk(busy === 1'b0 && !scl_low && !sda_low, "R8 no restart after ignored request",
          int'({busy, scl_low, sda_low}), 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung actual=%0d expected<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    dev_addr = 7'h00;
    reg_idx  = 8'h00;
    tgt_low  = 1'b0;
    exp_rd   = 8'h00;
    repeat (3) @(negedge clk);
    chk(!scl_low && !sda_low, "R1 lines in reset", int'({scl_low, sda_low}), 0);
    chk(!busy && !done && !ack_err, "R1 flags in reset", int'({busy, done, ack_err}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd_data === 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
    chk(!busy && !scl_low && !sda_low, "R1 idle after reset", int'({busy, scl_low, sda_low}), 0);

    run_txn(7'h50, 8'h3C, 8'hA5, 1'b1, 1'b1, 1'b0);
    run_txn(7'h2A, 8'hFF, 8'h5A, 1'b1, 1'b1, 1'b0);
    run_txn(7'h11, 8'h04, 8'hC3, 1'b0, 1'b1, 1'b0);
    run_txn(7'h7F, 8'h00, 8'h99, 1'b1, 1'b0, 1'b0);
    run_txn(7'h01, 8'h80, 8'h01, 1'b1, 1'b1, 1'b1);
    run_txn(7'h00, 8'h55, 8'hFF, 1'b1, 1'b1, 1'b0);
    run_txn(7'h3B, 8'hAA, 8'h00, 1'b0, 1'b0, 1'b1);
    finish_run();
  end
endmodule